// File: doc/BRIEF.md
# Memory Type Resolver

This block works out the effective cache memory type of a physical page. It reads its configuration as plain input vectors from a neighbouring range register file. These are a global enable, a fixed-range enable, an 8-bit default type, an 88-byte array of fixed-range types for the first megabyte, and a set of variable base/mask pairs. A request is one address plus a one-cycle start pulse. After a bounded number of cycles the block returns an 8-bit type code with a one-cycle done pulse.

Resolution follows a fixed order. If the global enable is off, every page is uncacheable. Otherwise, when fixed ranges are on and the page lies below 1 MB, the matching fixed byte is the answer. Otherwise the variable entries are visited one per clock, and each participating match is merged into a running type by architectural precedence. If no entry matches, the default type is returned. The configuration inputs must stay steady while a request is in flight.

Type codes: uncacheable 0, write-combining 1, write-through 4, write-protect 5, write-back 6.

The controller has four states. ST_IDLE waits for start; start captures the address and moves to ST_CLASSIFY. ST_CLASSIFY goes to ST_DONE for a disabled or fixed-range answer, and to ST_SCAN otherwise. ST_SCAN stays in place while entries remain. It moves to ST_DONE on an uncacheable match, on an undefined conflict, or after the last entry. ST_DONE always returns to ST_IDLE.

Top module: `memtype_resolver`

## Requirements
- R1: When glob_en_i is 0 the result is 0 (uncacheable) for every address, and done comes 2 clock edges after the edge that samples start.
- R2: When glob_en_i and fix_en_i are 1 and the address is below 0x100000, the result is byte k of fixed_bytes_i (bits 8k+7..8k). Here k is addr>>16 below 0x80000, 8+((addr-0x80000)>>14) below 0xC0000, and 24+((addr-0xC0000)>>12) otherwise. Done comes 2 edges after start.
- R3: With fix_en_i at 0, or for addresses at or above 0x100000, the fixed array is not used and the variable entries decide.
- R4: Variable entry k (base and mask at bits k*PA_W upward) takes part only when bit 11 of its mask is 1. It matches when (addr & m) equals (base & m), with m being the mask with bits 11..0 cleared. Its type is base bits 7..0.
- R5: When every matching entry has the same type, that type is the result.
- R6: A matching entry of type 0 makes the result 0 and ends the scan at that entry. For entry k, done comes 3+k edges after start.
- R7: When the matching types are only write-through (4) and write-back (6), the result is 4.
- R8: Any other conflicting pair of matching types gives 6 and ends the scan at the entry that produced the conflict.
- R9: When no participating entry matches, the result is dflt_type_i.
- R10: done_o is high for exactly one cycle per accepted request. A scan that runs through all entries raises done NUM_VAR+2 edges after start. After reset, done_o and mem_type_o are 0.
- R11: A start that arrives while a request is in flight is ignored. The address is captured at start, so later changes of addr_i do not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request pulse |
| addr_i | input | PA_W | Page-aligned physical address |
| glob_en_i | input | 1 | Global memory-type enable |
| fix_en_i | input | 1 | Fixed-range enable |
| dflt_type_i | input | 8 | Default memory type |
| fixed_bytes_i | input | 704 | 88 fixed-range type bytes, byte k at bits 8k+7..8k |
| vr_base_i | input | NUM_VAR*PA_W | Variable entry bases, type in bits 7..0 |
| vr_mask_i | input | NUM_VAR*PA_W | Variable entry masks, participate flag in bit 11 |
| done_o | output | 1 | One-cycle result strobe |
| mem_type_o | output | 8 | Resolved memory type, held until the next result |

## Verification
Every 4 KB page of the first megabyte is tried with fixed ranges on, against a byte pattern that differs from one neighbouring slot to the next. Any error in a segment boundary or a granule shift therefore shows up as a wrong code. A 128 MB sweep at 1 MB steps runs over a hand-built table that contains a same-type overlap, a write-through/write-back overlap, an uncacheable overlap, an undefined write-combining/write-back clash, a disabled entry and an uncovered region. The measured latency tells a scan that stopped early apart from one that ran to the end. Seeded random tables then mix these cases in new combinations, and one dedicated sequence issues a second start and an address change while the first request is still running.

// File: rtl/mtres_pkg.sv
package mtres_pkg;

    localparam logic [7:0] MT_UC = 8'd0;
    localparam logic [7:0] MT_WC = 8'd1;
    localparam logic [7:0] MT_WT = 8'd4;
    localparam logic [7:0] MT_WP = 8'd5;
    localparam logic [7:0] MT_WB = 8'd6;

    // fixed-range layout: 8 x 64K, 16 x 16K, 64 x 4K
    localparam int FIX_SLOTS   = 88;
    localparam int FIX_SLOT_W  = 7;
    localparam int SEG1_BASE   = 8;
    localparam int SEG2_BASE   = 24;
    localparam int PAGE_BITS   = 12;
    localparam int LOW_MB_BITS = 20;
    localparam int VR_FLAG_BIT = 11;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CLASSIFY,
        ST_SCAN,
        ST_DONE
    } rstate_e;

endpackage

// File: rtl/mtres_fixed_index.sv
module mtres_fixed_index
    import mtres_pkg::*;
#(
    parameter int PA_W = 36
) (
    input  logic [PA_W-1:0]       addr,
    output logic                  in_low_mb,
    output logic [FIX_SLOT_W-1:0] slot
);

    always_comb begin
        in_low_mb = (addr[PA_W-1:LOW_MB_BITS] == '0);
        if (!addr[19]) begin
            // 64K granules from 0
            slot = FIX_SLOT_W'(addr[18:16]);
        end else if (!addr[18]) begin
            // 16K granules from 0x80000
            slot = FIX_SLOT_W'(SEG1_BASE) + FIX_SLOT_W'(addr[17:14]);
        end else begin
            // 4K granules from 0xC0000
            slot = FIX_SLOT_W'(SEG2_BASE) + FIX_SLOT_W'(addr[17:12]);
        end
    end

endmodule

// File: rtl/mtres_var_probe.sv
module mtres_var_probe
    import mtres_pkg::*;
#(
    parameter int PA_W    = 36,
    parameter int NUM_VAR = 8,
    localparam int IDX_W  = (NUM_VAR > 1) ? $clog2(NUM_VAR) : 1
) (
    input  logic [NUM_VAR*PA_W-1:0] bases,
    input  logic [NUM_VAR*PA_W-1:0] masks,
    input  logic [IDX_W-1:0]        sel,
    input  logic [PA_W-1:0]         addr,
    output logic                    hit,
    output logic [7:0]              entry_type
);

    logic [PA_W-1:0] base_arr [NUM_VAR];
    logic [PA_W-1:0] mask_arr [NUM_VAR];

    for (genvar k = 0; k < NUM_VAR; k++) begin : g_unpack
        assign base_arr[k] = bases[k*PA_W +: PA_W];
        assign mask_arr[k] = masks[k*PA_W +: PA_W];
    end

    logic [PA_W-1:0] cur_base;
    logic [PA_W-1:0] cur_mask;
    logic [PA_W-1:0] cmp_mask;

    always_comb begin
        cur_base   = base_arr[sel];
        cur_mask   = mask_arr[sel];
        cmp_mask   = {cur_mask[PA_W-1:PAGE_BITS], {PAGE_BITS{1'b0}}};
        entry_type = cur_base[7:0];
        hit        = cur_mask[VR_FLAG_BIT] &&
                     ((addr & cmp_mask) == (cur_base & cmp_mask));
    end

endmodule

// File: rtl/mtres_merge.sv
module mtres_merge
    import mtres_pkg::*;
(
    input  logic       acc_vld,
    input  logic [7:0] acc_type,
    input  logic [7:0] cur_type,
    output logic [7:0] nxt_type,
    output logic       stop
);

    function automatic logic is_wt_wb(input logic [7:0] t);
        return (t == MT_WT) || (t == MT_WB);
    endfunction

    always_comb begin
        stop     = 1'b0;
        nxt_type = cur_type;
        if (cur_type == MT_UC) begin
            stop     = 1'b1;
            nxt_type = MT_UC;
        end else if (!acc_vld) begin
            nxt_type = cur_type;
        end else if (acc_type == cur_type) begin
            nxt_type = acc_type;
        end else if (is_wt_wb(acc_type) && is_wt_wb(cur_type)) begin
            nxt_type = MT_WT;
        end else begin
            stop     = 1'b1;
            nxt_type = MT_WB;
        end
    end

endmodule

// File: rtl/memtype_resolver.sv
module memtype_resolver
    import mtres_pkg::*;
#(
    parameter int PA_W    = 36,
    parameter int NUM_VAR = 8,
    localparam int IDX_W  = (NUM_VAR > 1) ? $clog2(NUM_VAR) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic [PA_W-1:0]         addr_i,
    input  logic                    glob_en_i,
    input  logic                    fix_en_i,
    input  logic [7:0]              dflt_type_i,
    input  logic [FIX_SLOTS*8-1:0]  fixed_bytes_i,
    input  logic [NUM_VAR*PA_W-1:0] vr_base_i,
    input  logic [NUM_VAR*PA_W-1:0] vr_mask_i,
    output logic                    done_o,
    output logic [7:0]              mem_type_o
);

    rstate_e state;
    rstate_e state_nxt;

    logic [PA_W-1:0]       addr_q;
    logic [IDX_W-1:0]      idx_q;
    logic                  acc_vld_q;
    logic [7:0]            acc_q;
    logic [7:0]            res_q;

    logic                  low_mb;
    logic [FIX_SLOT_W-1:0] fix_slot;
    logic [7:0]            fix_type;
    logic                  probe_hit;
    logic [7:0]            probe_type;
    logic [7:0]            merge_type;
    logic                  merge_stop;
    logic                  last_entry;
    logic                  use_fixed;

    mtres_fixed_index #(.PA_W(PA_W)) u_fix (
        .addr      (addr_q),
        .in_low_mb (low_mb),
        .slot      (fix_slot)
    );

    mtres_var_probe #(.PA_W(PA_W), .NUM_VAR(NUM_VAR)) u_probe (
        .bases      (vr_base_i),
        .masks      (vr_mask_i),
        .sel        (idx_q),
        .addr       (addr_q),
        .hit        (probe_hit),
        .entry_type (probe_type)
    );

    mtres_merge u_merge (
        .acc_vld  (acc_vld_q),
        .acc_type (acc_q),
        .cur_type (probe_type),
        .nxt_type (merge_type),
        .stop     (merge_stop)
    );

    assign fix_type   = fixed_bytes_i[fix_slot*8 +: 8];
    assign last_entry = (idx_q == IDX_W'(NUM_VAR - 1));
    assign use_fixed  = fix_en_i && low_mb;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:     if (start_i) state_nxt = ST_CLASSIFY;
            ST_CLASSIFY: begin
                if (!glob_en_i || use_fixed) state_nxt = ST_DONE;
                else                         state_nxt = ST_SCAN;
            end
            ST_SCAN:     begin
                if ((probe_hit && merge_stop) || last_entry) state_nxt = ST_DONE;
            end
            ST_DONE:     state_nxt = ST_IDLE;
            default:     state_nxt = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q    <= '0;
            idx_q     <= '0;
            acc_vld_q <= 1'b0;
            acc_q     <= MT_UC;
            res_q     <= MT_UC;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start_i) addr_q <= addr_i;
                end
                ST_CLASSIFY: begin
                    idx_q     <= '0;
                    acc_vld_q <= 1'b0;
                    if (!glob_en_i)     res_q <= MT_UC;
                    else if (use_fixed) res_q <= fix_type;
                end
                ST_SCAN: begin
                    idx_q <= idx_q + IDX_W'(1);
                    if (probe_hit) begin
                        acc_q     <= merge_type;
                        acc_vld_q <= 1'b1;
                    end
                    if (probe_hit && (merge_stop || last_entry)) begin
                        res_q <= merge_type;
                    end else if (last_entry) begin
                        res_q <= acc_vld_q ? acc_q : dflt_type_i;
                    end
                end
                ST_DONE: ;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        done_o     = (state == ST_DONE);
        mem_type_o = res_q;
    end

endmodule

module memtype_resolver_chk
    import mtres_pkg::*;
#(
    parameter int PA_W    = 36,
    parameter int NUM_VAR = 8
) (
    input logic            clk,
    input logic            rst_n,
    input rstate_e         st,
    input logic            start_i,
    input logic            glob_en_i,
    input logic            fix_en_i,
    input logic [PA_W-1:0] addr_q,
    input logic            probe_hit,
    input logic [7:0]      probe_type,
    input logic            done_o,
    input logic [7:0]      mem_type_o
);

    localparam int CNT_W = $clog2(NUM_VAR + 4) + 1;
    logic [CNT_W-1:0] busy_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             busy_cnt <= '0;
        else if (st == ST_IDLE) busy_cnt <= '0;
        else                    busy_cnt <= busy_cnt + CNT_W'(1);
    end

    a_r1_disabled_uc: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_CLASSIFY && !glob_en_i) |=> (done_o && mem_type_o == MT_UC));

    a_r2_fixed_fast: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_CLASSIFY && glob_en_i && fix_en_i &&
         addr_q[PA_W-1:LOW_MB_BITS] == '0) |=> done_o);

    a_r6_uc_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SCAN && probe_hit && probe_type == MT_UC) |=> (done_o && mem_type_o == MT_UC));

    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r10_busy_bound: assert property (@(posedge clk) disable iff (!rst_n)
        busy_cnt <= CNT_W'(NUM_VAR + 2));

    a_r11_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE && start_i) |=> $stable(addr_q));

endmodule

bind memtype_resolver memtype_resolver_chk #(.PA_W(PA_W), .NUM_VAR(NUM_VAR)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .st         (state),
    .start_i    (start_i),
    .glob_en_i  (glob_en_i),
    .fix_en_i   (fix_en_i),
    .addr_q     (addr_q),
    .probe_hit  (probe_hit),
    .probe_type (probe_type),
    .done_o     (done_o),
    .mem_type_o (mem_type_o)
);

// File: tb/memtype_resolver_bench.sv
`timescale 1ns/1ps
module memtype_resolver_bench;

    localparam int PW = 36;
    localparam int NV = 8;
    localparam int NF = 88;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [PW-1:0] addr_i = '0;
    logic genen = 1'b0;
    logic fixen = 1'b0;
    logic [7:0] dflt = 8'd0;
    logic [NF*8-1:0] fix_vec;
    logic [NV*PW-1:0] base_vec;
    logic [NV*PW-1:0] mask_vec;
    logic done_o;
    logic [7:0] mem_type_o;

    logic [PW-1:0] base_q [NV];
    logic [PW-1:0] mask_q [NV];
    logic [7:0]    fix_b  [NF];

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    always_comb begin
        for (int k = 0; k < NV; k++) begin
            base_vec[k*PW +: PW] = base_q[k];
            mask_vec[k*PW +: PW] = mask_q[k];
        end
        for (int i = 0; i < NF; i++) fix_vec[i*8 +: 8] = fix_b[i];
    end

    memtype_resolver #(.PA_W(PW), .NUM_VAR(NV)) u_memtype_resolver (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .addr_i        (addr_i),
        .glob_en_i     (genen),
        .fix_en_i      (fixen),
        .dflt_type_i   (dflt),
        .fixed_bytes_i (fix_vec),
        .vr_base_i     (base_vec),
        .vr_mask_i     (mask_vec),
        .done_o        (done_o),
        .mem_type_o    (mem_type_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int fix_slot(input longint a);
        if (a < 'h80000)      return int'(a >> 16);
        else if (a < 'hC0000) return 8 + int'((a - 'h80000) >> 14);
        else                  return 24 + int'((a - 'hC0000) >> 12);
    endfunction

    function automatic bit wtwb(input int t);
        return (t == 4) || (t == 6);
    endfunction

    // expected type, latency in edges after the start edge, and requirement tag
    task automatic model(input logic [PW-1:0] a, output int t, output int lat, output string req);
        int acc = -1;
        int hits = 0;
        bit mix = 0;
        logic [PW-1:0] m;
        if (!genen) begin
            t = 0; lat = 2; req = "R1"; return;
        end
        if (fixen && a < 'h100000) begin
            t = fix_b[fix_slot(a)]; lat = 2; req = "R2"; return;
        end
        for (int k = 0; k < NV; k++) begin
            m = {mask_q[k][PW-1:12], 12'h000};
            if (mask_q[k][11] && ((a & m) == (base_q[k] & m))) begin
                int cur = int'(base_q[k][7:0]);
                hits++;
                if (cur == 0) begin
                    t = 0; lat = 3 + k; req = "R6"; return;
                end else if (acc == -1) acc = cur;
                else if (acc == cur) ;
                else if (wtwb(acc) && wtwb(cur)) begin acc = 4; mix = 1; end
                else begin
                    t = 6; lat = 3 + k; req = "R8"; return;
                end
            end
        end
        lat = NV + 2;
        if (acc == -1) begin t = int'(dflt); req = "R9"; end
        else begin
            t = acc;
            req = mix ? "R7" : ((hits > 1) ? "R5" : "R4");
        end
    endtask

    task automatic run_one(input logic [PW-1:0] a, input string extra);
        int et, el, lat;
        string req;
        model(a, et, el, req);
        req = {req, extra};
        @(negedge clk); addr_i = a; start_i = 1'b1;
        @(negedge clk); start_i = 1'b0; lat = 1;
        while (!done_o && lat < 64) begin @(negedge clk); lat++; end
        check(done_o == 1'b1, req, "done seen", longint'(done_o), 1);
        check(int'(mem_type_o) == et, req, "type", longint'(mem_type_o), et);
        check(lat == el, {req, "/R10"}, "latency", lat, el);
        @(negedge clk);
        check(done_o == 1'b0, "R10", "done one cycle", longint'(done_o), 0);
    endtask

    function automatic logic [PW-1:0] mk_mask(input longint size, input bit en);
        return ~(PW'(size) - PW'(1)) | (en ? PW'('h800) : PW'(0));
    endfunction

    task automatic clear_vars();
        for (int k = 0; k < NV; k++) begin base_q[k] = '0; mask_q[k] = '0; end
    endtask

    task automatic setup_a();
        clear_vars();
        base_q[0] = PW'('h0000000) | 6; mask_q[0] = mk_mask(64 << 20, 1);
        base_q[1] = PW'('h1000000) | 4; mask_q[1] = mk_mask(16 << 20, 1);
        base_q[2] = PW'('h2000000) | 0; mask_q[2] = mk_mask(8 << 20, 1);
        base_q[3] = PW'('h3000000) | 1; mask_q[3] = mk_mask(4 << 20, 1);
        base_q[4] = PW'('h3800000) | 0; mask_q[4] = mk_mask(1 << 20, 0);
        base_q[5] = PW'('h0000000) | 6; mask_q[5] = mk_mask(32 << 20, 1);
        base_q[6] = PW'('h5000000) | 5; mask_q[6] = mk_mask(4 << 20, 1);
        dflt = 8'd1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        int types [5] = '{0, 1, 4, 5, 6};
        int rtypes [7] = '{6, 6, 4, 4, 1, 5, 0};
        void'($urandom(32'h5eed));
        clear_vars();
        for (int i = 0; i < NF; i++) fix_b[i] = 8'(types[(i * 3 + 1) % 5]);

        // reset state (R10)
        repeat (3) @(negedge clk);
        check(done_o == 1'b0, "R10", "reset done", longint'(done_o), 0);
        check(mem_type_o == 8'd0, "R10", "reset type", longint'(mem_type_o), 0);
        rst_n = 1'b1;

        // R1: globally disabled
        setup_a(); genen = 1'b0; fixen = 1'b1;
        for (int i = 0; i < 16; i++) run_one(PW'(i) << 22 | PW'(i) << 12, "");

        // R2: every page of the first megabyte through the fixed array
        genen = 1'b1; fixen = 1'b1;
        for (int p = 0; p < 256; p++) run_one(PW'(p) << 12, "");

        // R3: fixed on but above 1 MB, and fixed off below 1 MB
        for (int i = 1; i < 8; i++) run_one(PW'(i) << 20, "/R3");
        fixen = 1'b0;
        for (int p = 0; p < 256; p += 17) run_one(PW'(p) << 12, "/R3");

        // R4..R9 over the hand-built table
        for (int mb = 0; mb < 128; mb++) run_one(PW'(mb) << 20, "");

        // R11: second start and address change during a request
        begin
            int lat = 1;
            int extra_done = 0;
            @(negedge clk); addr_i = PW'('h2000000); start_i = 1'b1;
            @(negedge clk); start_i = 1'b0; addr_i = PW'('h5000000);
            @(negedge clk); start_i = 1'b1; lat++;
            @(negedge clk); start_i = 1'b0; lat++;
            while (!done_o && lat < 64) begin @(negedge clk); lat++; end
            check(mem_type_o == 8'd0, "R11", "type of captured address", longint'(mem_type_o), 0);
            check(lat == 5, "R11", "latency", lat, 5);
            for (int c = 0; c < 16; c++) begin
                @(negedge clk);
                if (done_o) extra_done++;
            end
            check(extra_done == 0, "R11", "extra done pulses", extra_done, 0);
        end

        // seeded random tables
        for (int cfg = 0; cfg < 4; cfg++) begin
            clear_vars();
            for (int k = 0; k < NV; k++) begin
                longint sz = longint'(1) << (20 + ($urandom % 6));
                longint bs = (longint'($urandom % 64) << 20) & ~(sz - 1);
                base_q[k] = PW'(bs) | PW'(rtypes[$urandom % 7]);
                mask_q[k] = mk_mask(sz, ($urandom % 4) != 0);
            end
            dflt = 8'(types[cfg % 5]);
            fixen = cfg[0];
            for (int mb = 0; mb < 64; mb++) run_one(PW'(mb) << 20 | PW'(cfg) << 13, "");
        end

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule